// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Controller

This block is the digital front end of a two-channel converter. A host drives three serial pins: a chip select, a serial clock and a data line. The block samples them with a fast system clock and collects a 16-bit command word, most significant bit first, on each serial-clock rising edge while chip select is low. The word is run when chip select returns high. Each channel has two 13-bit registers. The input register is a staging copy. The converter register holds the code presented to the converter. Commands can stage one channel, stage and transfer, write everything at once, or transfer staged values. Other commands shut a channel down, drive a general-purpose output pin or pick the serial-output clock edge.

Software shutdown is allowed only while the `sd_enable` pin is high. A falling edge on that pin wakes any sleeping channel, with its code unchanged. A synchronous active-low `clear_n` zeroes all four code registers, and the asynchronous `rst_n` also restores the default pin states. The serial pins pass through two-flop synchronizers, so the system clock must run at least four times as fast as the serial clock.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Word bits are taken MSB first on serial-clock rising edges while `spi_cs_n` is low. Bit 15 is the address bit, bits 14:13 are the control bits and bits 12:0 are the data. A command takes effect only after `spi_cs_n` rises.
- R2: Primary code 001 writes data to input register A and 101 writes data to input register B. Neither changes `code_a` or `code_b`.
- R3: Code 010 writes data to input A and to converter A, and copies input B into converter B. Code 110 is the mirror of 010. Code 011 writes data to all four registers.
- R4: Code 100 copies both input registers into the converter registers. With primary 000, sub-code 001 (data bits 12:10) copies A only and sub-code 101 copies B only.
- R5: Code 111 shuts down both channels. With primary 000, sub-code 110 shuts down A and sub-code 111 shuts down B. A shutdown command has no effect while `sd_enable` is low.
- R6: Any command that writes a channel's converter register clears that channel's sleep flag. A command that only writes an input register leaves the sleep flag set.
- R7: A high-to-low edge on `sd_enable` clears both sleep flags and leaves the codes unchanged.
- R8: With primary 000, sub-code 010 drives `gp_out` low and sub-code 011 drives it high. Sub-code 100 copies data bit 9 into `dout_rise_mode`, where 1 selects the rising edge.
- R9: A word with primary 000 and sub-code 000 changes no output.
- R10: A frame of any length other than 16 bits is discarded, and no output or register changes.
- R11: When `clear_n` is low, all input and converter registers become zero. This takes priority over a command that completes in the same cycle, and that command is dropped.
- R12: After `rst_n` every code is zero, both sleep flags are low, `gp_out` is low and `dout_rise_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Active-low frame select, asynchronous |
| spi_mosi | input | 1 | Serial data, asynchronous |
| clear_n | input | 1 | Synchronous active-low code clear |
| sd_enable | input | 1 | High permits shutdown; a falling edge wakes channels |
| code_a | output | 13 | Converter register of channel A |
| code_b | output | 13 | Converter register of channel B |
| sleep_a | output | 1 | Channel A shut down |
| sleep_b | output | 1 | Channel B shut down |
| gp_out | output | 1 | General-purpose output bit |
| dout_rise_mode | output | 1 | Serial-output edge select |

## Verification
The bench first stages a different value into each input register with the load-only codes. Transfers then show which input register feeds which converter register. Because the staged values differ from the last data word, the three load-and-transfer codes can be told apart. The shutdown and wake tests run with `sd_enable` low and then high, and they pair load-only with load-and-transfer, which separates the lockout from the wake rule. The bench also sends short and long frames, sends a command while `clear_n` is held low, and sends distinct data patterns (alternating bits, all ones). These catch bit-order slips, miscounted frames and lost clear priority.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  typedef enum logic [2:0] {
    OP_EXT      = 3'b000,
    OP_STAGE_A  = 3'b001,
    OP_LDX_A    = 3'b010,
    OP_WRITE_ALL= 3'b011,
    OP_XFER_ALL = 3'b100,
    OP_STAGE_B  = 3'b101,
    OP_LDX_B    = 3'b110,
    OP_SLEEP_ALL= 3'b111
  } prim_op_e;

  typedef enum logic [2:0] {
    SUB_NOP     = 3'b000,
    SUB_XFER_A  = 3'b001,
    SUB_GP_LOW  = 3'b010,
    SUB_GP_HIGH = 3'b011,
    SUB_EDGE    = 3'b100,
    SUB_XFER_B  = 3'b101,
    SUB_SLEEP_A = 3'b110,
    SUB_SLEEP_B = 3'b111
  } sub_op_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int NPINS  = 3,
  parameter int STAGES = 2,
  parameter logic [NPINS-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] prev;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[p]}};
      else        chain <= {chain[STAGES-2:0], pins[p]};
    end
    assign level[p] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_high,
  input  logic              cs_rise,
  input  logic              bit_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      word <= '0;
    end else if (cs_high) begin
      cnt <= '0;
    end else if (sck_rise) begin
      word <= {word[WORD_W-2:0], bit_in};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  assign word_valid = cs_rise && (cnt == CNT_FULL);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (cnt == '0)); // R1
endmodule

// File: rtl/chan_regs.sv
module chan_regs
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_n,
  input  logic              sd_enable,
  input  logic              word_valid,
  input  logic [CODE_W+2:0] word,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              sleep_a,
  output logic              sleep_b,
  output logic              gp_out,
  output logic              dout_rise_mode
);
  logic [CODE_W-1:0] stage_a, stage_b;
  logic [CODE_W-1:0] data;
  prim_op_e          prim;
  sub_op_e           sub;
  logic              go, sd_prev, sd_fall;
  logic st_a, st_b, dx_a, dx_b, cp_a, cp_b, zz_a, zz_b, gp_wr, md_wr;

  assign data    = word[CODE_W-1:0];
  assign prim    = prim_op_e'(word[CODE_W+2:CODE_W]);
  assign sub     = sub_op_e'(word[CODE_W-1:CODE_W-3]);
  assign go      = word_valid && clear_n;
  assign sd_fall = sd_prev && !sd_enable;

  always_comb begin
    st_a = 1'b0; st_b = 1'b0;   // stage from data
    dx_a = 1'b0; dx_b = 1'b0;   // converter from data
    cp_a = 1'b0; cp_b = 1'b0;   // converter from stage
    zz_a = 1'b0; zz_b = 1'b0;   // shutdown request
    gp_wr = 1'b0; md_wr = 1'b0;
    unique case (prim)
      OP_STAGE_A:   st_a = 1'b1;
      OP_STAGE_B:   st_b = 1'b1;
      OP_LDX_A:     begin st_a = 1'b1; dx_a = 1'b1; cp_b = 1'b1; end
      OP_LDX_B:     begin st_b = 1'b1; dx_b = 1'b1; cp_a = 1'b1; end
      OP_WRITE_ALL: begin st_a = 1'b1; st_b = 1'b1; dx_a = 1'b1; dx_b = 1'b1; end
      OP_XFER_ALL:  begin cp_a = 1'b1; cp_b = 1'b1; end
      OP_SLEEP_ALL: begin zz_a = 1'b1; zz_b = 1'b1; end
      OP_EXT: begin
        unique case (sub)
          SUB_XFER_A:  cp_a = 1'b1;
          SUB_XFER_B:  cp_b = 1'b1;
          SUB_SLEEP_A: zz_a = 1'b1;
          SUB_SLEEP_B: zz_b = 1'b1;
          SUB_GP_LOW, SUB_GP_HIGH: gp_wr = 1'b1;
          SUB_EDGE:    md_wr = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= '0; stage_b <= '0; code_a <= '0; code_b <= '0;
    end else if (!clear_n) begin
      stage_a <= '0; stage_b <= '0; code_a <= '0; code_b <= '0;
    end else if (word_valid) begin
      if (st_a) stage_a <= data;
      if (st_b) stage_b <= data;
      if (dx_a) code_a <= data; else if (cp_a) code_a <= stage_a;
      if (dx_b) code_b <= data; else if (cp_b) code_b <= stage_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_a <= 1'b0; sleep_b <= 1'b0; gp_out <= 1'b0;
      dout_rise_mode <= 1'b0; sd_prev <= 1'b0;
    end else begin
      sd_prev <= sd_enable;
      if (sd_fall) begin
        sleep_a <= 1'b0; sleep_b <= 1'b0;
      end else if (go) begin
        if (dx_a || cp_a)            sleep_a <= 1'b0;
        else if (zz_a && sd_enable)  sleep_a <= 1'b1;
        if (dx_b || cp_b)            sleep_b <= 1'b0;
        else if (zz_b && sd_enable)  sleep_b <= 1'b1;
      end
      if (go && gp_wr) gp_out <= word[CODE_W-3];
      if (go && md_wr) dout_rise_mode <= word[CODE_W-4];
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (code_a == '0 && code_b == '0)); // R11
  AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_enable && !sleep_a && !sleep_b) |=> (!sleep_a && !sleep_b)); // R5
  AST_WAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_prev && !sd_enable) |=> (!sleep_a && !sleep_b)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && clear_n) |=> ($stable(code_a) && $stable(code_b) && $stable(gp_out))); // R10
  AST_SLEEP_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_a) |-> $past(word_valid)); // R5
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl #(
  parameter int CODE_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              clear_n,
  input  logic              sd_enable,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              sleep_a,
  output logic              sleep_b,
  output logic              gp_out,
  output logic              dout_rise_mode
);
  localparam int WORD_W = CODE_W + 3;

  logic [2:0] lvl, rse, fal;
  logic              word_valid;
  logic [WORD_W-1:0] word;
  logic              unused_edges;

  // pin order: 2 = select, 1 = clock, 0 = data
  pin_sync #(.NPINS(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins({spi_cs_n, spi_sck, spi_mosi}),
    .level(lvl), .rise(rse), .fall(fal)
  );

  assign unused_edges = ^{fal, rse[0]};

  cmd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(rse[1]), .cs_high(lvl[2]),
    .cs_rise(rse[2]), .bit_in(lvl[0]), .word_valid(word_valid), .word(word)
  );

  chan_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .sd_enable(sd_enable),
    .word_valid(word_valid), .word(word),
    .code_a(code_a), .code_b(code_b), .sleep_a(sleep_a), .sleep_b(sleep_b),
    .gp_out(gp_out), .dout_rise_mode(dout_rise_mode)
  );
endmodule

// File: tb/dac_cmd_ctrl_bench.sv
module dac_cmd_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, clear_n = 1'b1, sd_en = 1'b1;
  logic [12:0] code_a, code_b;
  logic sleep_a, sleep_b, gp_out, dmode;

  int checks = 0, errors = 0;
  bit settled = 0, done = 0;
  string req = "R12";

  int e_in_a = 0, e_in_b = 0, e_da = 0, e_db = 0;
  bit e_sa = 0, e_sb = 0, e_gp = 0, e_md = 0;

  always #2 clk = ~clk;

  dac_cmd_ctrl u_dac_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .clear_n(clear_n), .sd_enable(sd_en), .code_a(code_a), .code_b(code_b),
    .sleep_a(sleep_a), .sleep_b(sleep_b), .gp_out(gp_out), .dout_rise_mode(dmode)
  );

  always @(negedge clk) begin
    if (settled && rst_n) begin
      checks++;
      if (code_a != e_da[12:0] || code_b != e_db[12:0] || sleep_a != e_sa ||
          sleep_b != e_sb || gp_out != e_gp || dmode != e_md) begin
        errors++;
        $display("FAIL %s: got a=%h b=%h sa=%b sb=%b gp=%b md=%b exp a=%h b=%h sa=%b sb=%b gp=%b md=%b",
          req, code_a, code_b, sleep_a, sleep_b, gp_out, dmode,
          e_da[12:0], e_db[12:0], e_sa, e_sb, e_gp, e_md);
      end
    end
  end

  task automatic model(input logic [15:0] w);
    int d = int'(w[12:0]);
    logic [2:0] sub = w[12:10];
    case (w[15:13])
      3'b001: e_in_a = d;
      3'b101: e_in_b = d;
      3'b010: begin e_in_a = d; e_da = d; e_db = e_in_b; e_sa = 0; e_sb = 0; end
      3'b110: begin e_in_b = d; e_db = d; e_da = e_in_a; e_sa = 0; e_sb = 0; end
      3'b011: begin e_in_a = d; e_in_b = d; e_da = d; e_db = d; e_sa = 0; e_sb = 0; end
      3'b100: begin e_da = e_in_a; e_db = e_in_b; e_sa = 0; e_sb = 0; end
      3'b111: if (sd_en) begin e_sa = 1; e_sb = 1; end
      default: case (sub)
        3'b001: begin e_da = e_in_a; e_sa = 0; end
        3'b101: begin e_db = e_in_b; e_sb = 0; end
        3'b110: if (sd_en) e_sa = 1;
        3'b111: if (sd_en) e_sb = 1;
        3'b010: e_gp = 0;
        3'b011: e_gp = 1;
        3'b100: e_md = w[9];
        default: ;
      endcase
    endcase
  endtask

  task automatic frame(input string r, input logic [15:0] w, input int nbits,
                       input bit hold_clear = 0);
    req = r;
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    settled = 0;
    if (hold_clear) clear_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (hold_clear) begin
      clear_n = 1'b1; e_in_a = 0; e_in_b = 0; e_da = 0; e_db = 0;
    end else if (nbits == 16) model(w);
    repeat (2) @(negedge clk);
    settled = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_sd(input string r, input bit v);
    req = r; settled = 0;
    @(negedge clk);
    if (sd_en && !v) begin e_sa = 0; e_sb = 0; end
    sd_en = v;
    repeat (3) @(negedge clk);
    settled = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settled = 1;
    repeat (5) @(negedge clk);                         // R12 reset state
    frame("R2", {3'b001, 13'h0AAA}, 16);               // stage A only
    frame("R2", {3'b101, 13'h1555}, 16);               // stage B only
    frame("R4", {3'b000, 3'b001, 10'h0}, 16);          // copy A
    frame("R4", {3'b000, 3'b101, 10'h0}, 16);          // copy B
    frame("R2", {3'b001, 13'h0123}, 16);
    frame("R4", {3'b100, 13'h1FFF}, 16);               // copy both
    frame("R3", {3'b010, 13'h1F0F}, 16);
    frame("R3", {3'b101, 13'h0042}, 16);
    frame("R3", {3'b110, 13'h0F0F}, 16);
    frame("R3", {3'b011, 13'h1FFF}, 16);
    frame("R1", {3'b011, 13'h1001}, 16);               // MSB/LSB order
    frame("R9", {3'b000, 3'b000, 10'h3FF}, 16);        // no effect
    frame("R8", {3'b000, 3'b011, 10'h0}, 16);
    frame("R8", {3'b000, 3'b100, 10'h200}, 16);
    frame("R8", {3'b000, 3'b010, 10'h0}, 16);
    frame("R8", {3'b000, 3'b100, 10'h000}, 16);
    frame("R8", {3'b000, 3'b100, 10'h200}, 16);
    set_sd("R5", 1'b0);
    frame("R5", {3'b111, 13'h0}, 16);                  // locked out
    frame("R5", {3'b000, 3'b110, 10'h0}, 16);
    set_sd("R5", 1'b1);
    frame("R5", {3'b000, 3'b110, 10'h0}, 16);          // sleep A
    frame("R6", {3'b001, 13'h0777}, 16);               // stays asleep
    frame("R6", {3'b000, 3'b001, 10'h0}, 16);          // wake A
    frame("R5", {3'b000, 3'b111, 10'h0}, 16);          // sleep B
    frame("R6", {3'b110, 13'h0333}, 16);               // wake
    frame("R5", {3'b111, 13'h0}, 16);
    set_sd("R7", 1'b0);                                // wake by edge
    set_sd("R7", 1'b1);
    frame("R10", {3'b011, 13'h0ABC}, 15);
    frame("R10", {3'b011, 13'h0ABC}, 17);
    frame("R10", {3'b111, 13'h0}, 3);
    frame("R11", {3'b011, 13'h1234}, 16, 1'b1);        // clear wins
    frame("R11", {3'b100, 13'h0}, 16);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule